// File: doc/BRIEF.md
# Fault Status and Interrupt Registers

This block is the register-side diagnostic logic for a multi-channel protected power switch. It keeps an interrupt mask register, a configuration register and two groups of status bits: one for supply-level faults and one for per-channel faults. Each status bit captures a fault flag produced by analog monitoring elsewhere on the chip. It also drives an active-low interrupt that a bus-level pin driver can use as an open-drain output.

A single configuration bit selects between two status modes. In the first mode a fault is held until software reads the register that contains it. In the second mode status and interrupt follow the live fault flags. A self-test bit in the mask register forces every overvoltage status bit high so that software can confirm the reporting path. While the switch enable pin is low, the status bits freeze and the interrupt stays inactive.

The register port is a plain strobe interface and is always ready: every `rd_en` or `wr_en` strobe is taken in the cycle it is presented, so there is no back-pressure. Read data comes back one cycle later with `rd_valid`. A serial bus front end sits on this port.

Top module: `fault_status_regs`

## Requirements
- R1: After reset the mask register reads 0x00, the configuration register reads 0x1F, every status bit is 0, `irq_n` is 1 and `rd_valid` is 0.
- R2: A read strobe gives `rd_valid`=1 on the next cycle, with `rd_data` equal to the addressed register as it was before that read took effect. The address map is: 0x00 mask, 0x01 configuration, 0x02 identity, 0x03 supply status, 0x04 channel status for channels 1 and 2, 0x05 channel status for channels 3 and 4. Every other address reads 0x00. The identity register reads {2'b00, PART_ID[1:0], REV[3:0]}.
- R3: A write to 0x00 or 0x01 replaces that register on the next cycle. A write to any other address changes nothing that can be read back.
- R4: Supply status layout: bit 5 current-set fault, bit 4 conversion complete, bit 3 input overvoltage, bit 2 input undervoltage, bit 1 device-supply overvoltage, bit 0 device-supply undervoltage, bits 7:6 zero. Each channel nibble holds thermal (bit 3), overcurrent (bit 2), overvoltage (bit 1) and undervoltage (bit 0). The lower-numbered channel of a pair sits in bits 3:0.
- R5: With configuration bit 4 at 0 (latched mode) and the enable pin high, a flag seen at a clock edge sets its status bit, and the bit stays set until its register is read. The read returns 1 and clears the bit. If the flag is still present, the bit sets again one cycle later.
- R6: With configuration bit 4 at 1 (live mode) and the enable pin high, each status bit equals its flag one cycle later, and reads do not clear it.
- R7: While the enable pin is low, status bits keep their values and `irq_n` is 1. In latched mode a read still clears the register it reads.
- R8: `irq_n` is 0 exactly when the enable pin is high and some unmasked status bit is 1. A mask bit at 1 removes its group: bit 6 conversion complete, bit 5 thermal, bit 4 device-supply faults, bit 3 input faults, bit 2 overcurrent, bit 1 overvoltage, bit 0 undervoltage. The current-set fault cannot be masked.
- R9: When mask bit 7 is 1, configuration bits 3:0 are all 0 and the enable pin is high, the flag values seen are overvoltage 1 on the input, on the device supply and on every channel, and undervoltage 0 on all of them. If any configuration bit 3:0 is 1, mask bit 7 has no effect.
- R10: In latched mode, a read of address 0x06 also clears the conversion-complete status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Switch enable pin |
| ch_ts | input | NUM_CH | Per-channel thermal fault flags |
| ch_oc | input | NUM_CH | Per-channel overcurrent flags |
| ch_ov | input | NUM_CH | Per-channel output overvoltage flags |
| ch_uv | input | NUM_CH | Per-channel output undervoltage flags |
| iset_flt | input | 1 | Current-set resistor fault flag |
| vin_ov | input | 1 | Input supply overvoltage flag |
| vin_uv | input | 1 | Input supply undervoltage flag |
| vdd_ov | input | 1 | Device supply overvoltage flag |
| vdd_uv | input | 1 | Device supply undervoltage flag |
| adc_done | input | 1 | Conversion-complete pulse |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with NUM_CH=4, PART_ID=2'b01 and REV=4'h5. Four channels fill both channel status registers, so the nibble placement of every channel and the clear-by-register grouping can be observed. The non-default identity values make the identity read a real check of parameter placement rather than a match on zeros. Random runs mix mode and enable changes with sparse flags, so latched re-set after a read, frozen status and self-test entry and exit all occur.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  // register addresses
  localparam int A_MASK  = 0;
  localparam int A_CFG   = 1;
  localparam int A_ID    = 2;
  localparam int A_STAT1 = 3;
  localparam int A_CHST  = 4;
  localparam int A_ADC1  = 6;

  localparam logic [7:0] CFG_RST = 8'h1F;

  // configuration and mask bit positions
  localparam int CFG_LIVE  = 4;
  localparam int MSK_TEST  = 7;
  localparam int MSK_ACC   = 6;
  localparam int MSK_TS    = 5;
  localparam int MSK_VDD   = 4;
  localparam int MSK_VIN   = 3;
  localparam int MSK_OC    = 2;
  localparam int MSK_OV    = 1;
  localparam int MSK_UV    = 0;

  // supply status bit positions
  localparam int S1_ISET  = 5;
  localparam int S1_ACC   = 4;
  localparam int S1_VINOV = 3;
  localparam int S1_VINUV = 2;
  localparam int S1_VDDOV = 1;
  localparam int S1_VDDUV = 0;
  localparam int S1_W     = 6;

  // channel nibble bit positions
  localparam int CN_TS = 3;
  localparam int CN_OC = 2;
  localparam int CN_OV = 1;
  localparam int CN_UV = 0;
endpackage

// File: rtl/fsr_live.sv
module fsr_live #(
  parameter int NUM_CH = 4
) (
  input  logic                  selftest,
  input  logic                  iset_flt,
  input  logic                  adc_done,
  input  logic                  vin_ov,
  input  logic                  vin_uv,
  input  logic                  vdd_ov,
  input  logic                  vdd_uv,
  input  logic [NUM_CH-1:0]     ch_ts,
  input  logic [NUM_CH-1:0]     ch_oc,
  input  logic [NUM_CH-1:0]     ch_ov,
  input  logic [NUM_CH-1:0]     ch_uv,
  output logic [5:0]            s1_live,
  output logic [4*NUM_CH-1:0]   ch_live
);
  import fsr_pkg::*;

  // self-test forces overvoltage high and hides undervoltage
  always_comb begin
    s1_live           = '0;
    s1_live[S1_ISET]  = iset_flt;
    s1_live[S1_ACC]   = adc_done;
    s1_live[S1_VINOV] = vin_ov | selftest;
    s1_live[S1_VINUV] = vin_uv & ~selftest;
    s1_live[S1_VDDOV] = vdd_ov | selftest;
    s1_live[S1_VDDUV] = vdd_uv & ~selftest;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_live[4*c+CN_TS] = ch_ts[c];
    assign ch_live[4*c+CN_OC] = ch_oc[c];
    assign ch_live[4*c+CN_OV] = ch_ov[c] | selftest;
    assign ch_live[4*c+CN_UV] = ch_uv[c] & ~selftest;
  end
endmodule

// File: rtl/fsr_status_bank.sv
module fsr_status_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic         live_mode,
  input  logic [W-1:0] live,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bit_q <= 1'b0;
      else if (clr[b] && !live_mode)
        bit_q <= 1'b0;
      else if (upd_en)
        bit_q <= live_mode ? live[b] : (bit_q | live[b]);
    end
    assign q[b] = bit_q;
  end
endmodule

// File: rtl/fsr_irq.sv
module fsr_irq #(
  parameter int NUM_CH = 4
) (
  input  logic                en_pin,
  input  logic [6:0]          mask,
  input  logic [5:0]          s1,
  input  logic [4*NUM_CH-1:0] ch,
  output logic                irq_n
);
  import fsr_pkg::*;

  logic any_ts, any_oc, any_ov, any_uv, hit;

  always_comb begin
    any_ts = 1'b0;
    any_oc = 1'b0;
    any_ov = 1'b0;
    any_uv = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      any_ts = any_ts | ch[4*c+CN_TS];
      any_oc = any_oc | ch[4*c+CN_OC];
      any_ov = any_ov | ch[4*c+CN_OV];
      any_uv = any_uv | ch[4*c+CN_UV];
    end
    hit = s1[S1_ISET]
        | (s1[S1_ACC] & ~mask[MSK_ACC])
        | ((s1[S1_VDDOV] | s1[S1_VDDUV]) & ~mask[MSK_VDD])
        | ((s1[S1_VINOV] | s1[S1_VINUV]) & ~mask[MSK_VIN])
        | (any_ts & ~mask[MSK_TS])
        | (any_oc & ~mask[MSK_OC])
        | (any_ov & ~mask[MSK_OV])
        | (any_uv & ~mask[MSK_UV]);
    irq_n = ~(en_pin & hit);
  end
endmodule

// File: rtl/fault_status_regs.sv
module fault_status_regs #(
  parameter int         NUM_CH  = 4,    // 2 or 4 channels
  parameter int         ADDR_W  = 4,
  parameter logic [1:0] PART_ID = 2'b10,
  parameter logic [3:0] REV     = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_pin,
  input  logic [NUM_CH-1:0] ch_ts,
  input  logic [NUM_CH-1:0] ch_oc,
  input  logic [NUM_CH-1:0] ch_ov,
  input  logic [NUM_CH-1:0] ch_uv,
  input  logic              iset_flt,
  input  logic              vin_ov,
  input  logic              vin_uv,
  input  logic              vdd_ov,
  input  logic              vdd_uv,
  input  logic              adc_done,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              irq_n
);
  import fsr_pkg::*;

  localparam int CHW     = 4 * NUM_CH;
  localparam int CH_REGS = (NUM_CH + 1) / 2;

  logic [7:0]       mask_q, cfg_q;
  logic [S1_W-1:0]  s1_q, s1_live, s1_clr;
  logic [CHW-1:0]   ch_q, ch_live, ch_clr;
  logic             selftest, live_mode;
  logic [7:0]       rd_mux;
  logic [8*CH_REGS-1:0] ch_pad;

  assign live_mode = cfg_q[CFG_LIVE];
  assign selftest  = mask_q[MSK_TEST] & (cfg_q[3:0] == 4'h0) & en_pin;

  // configuration and mask registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 8'h00;
      cfg_q  <= CFG_RST;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_MASK)) mask_q <= wdata;
      if (addr == ADDR_W'(A_CFG))  cfg_q  <= wdata;
    end
  end

  fsr_live #(.NUM_CH(NUM_CH)) u_live (
    .selftest (selftest),
    .iset_flt (iset_flt),
    .adc_done (adc_done),
    .vin_ov   (vin_ov),
    .vin_uv   (vin_uv),
    .vdd_ov   (vdd_ov),
    .vdd_uv   (vdd_uv),
    .ch_ts    (ch_ts),
    .ch_oc    (ch_oc),
    .ch_ov    (ch_ov),
    .ch_uv    (ch_uv),
    .s1_live  (s1_live),
    .ch_live  (ch_live)
  );

  // read-clear selects: a read clears the register it returns
  always_comb begin
    s1_clr = (rd_en && addr == ADDR_W'(A_STAT1)) ? '1 : '0;
    if (rd_en && addr == ADDR_W'(A_ADC1))
      s1_clr[S1_ACC] = 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
    assign ch_clr[4*c +: 4] =
      {4{rd_en && (addr == ADDR_W'(A_CHST + c / 2))}};
  end

  fsr_status_bank #(.W(S1_W)) u_s1 (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (en_pin),
    .live_mode (live_mode),
    .live      (s1_live),
    .clr       (s1_clr),
    .q         (s1_q)
  );

  fsr_status_bank #(.W(CHW)) u_ch (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (en_pin),
    .live_mode (live_mode),
    .live      (ch_live),
    .clr       (ch_clr),
    .q         (ch_q)
  );

  fsr_irq #(.NUM_CH(NUM_CH)) u_irq (
    .en_pin (en_pin),
    .mask   (mask_q[6:0]),
    .s1     (s1_q),
    .ch     (ch_q),
    .irq_n  (irq_n)
  );

  // read multiplexer
  assign ch_pad = (8*CH_REGS)'(ch_q);

  always_comb begin
    int sel;
    sel    = int'(addr);
    rd_mux = 8'h00;
    if (sel == A_MASK)
      rd_mux = mask_q;
    else if (sel == A_CFG)
      rd_mux = cfg_q;
    else if (sel == A_ID)
      rd_mux = {2'b00, PART_ID, REV};
    else if (sel == A_STAT1)
      rd_mux = {2'b00, s1_q};
    else if (sel >= A_CHST && sel < A_CHST + CH_REGS)
      rd_mux = ch_pad[8*(sel-A_CHST) +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/fault_status_regs_chk.sv
module fault_status_regs_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en_pin,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     addr,
  input logic                  irq_n,
  input logic                  rd_valid,
  input logic [7:0]            mask_q,
  input logic [7:0]            cfg_q,
  input logic [5:0]            s1_q,
  input logic [4*NUM_CH-1:0]   ch_q
);
  // R2: read data valid follows the strobe by one cycle
  p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R7: interrupt inactive and status frozen while enable pin is low
  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pin |-> irq_n);
  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_pin && !rd_en) |=> ($stable(s1_q) && $stable(ch_q)));

  // R5: in latched mode only a read can drop a status bit
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[4] && !rd_en) |=>
      (((s1_q & $past(s1_q)) == $past(s1_q)) &&
       ((ch_q & $past(ch_q)) == $past(ch_q))));

  // R9: self-test drives the supply overvoltage bits high
  p_selftest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && mask_q[7] && cfg_q[3:0] == 4'h0 &&
     !(rd_en && addr == ADDR_W'(3))) |=> (s1_q[3] && s1_q[1]));
endmodule

bind fault_status_regs fault_status_regs_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/fault_status_regs_tb.sv
module fault_status_regs_tb;
  localparam int         NC  = 4;
  localparam int         AW  = 4;
  localparam logic [1:0] PID = 2'b01;
  localparam logic [3:0] RV  = 4'h5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_pin = 1'b0;
  logic [NC-1:0] ch_ts = '0, ch_oc = '0, ch_ov = '0, ch_uv = '0;
  logic          iset_flt = 0, vin_ov = 0, vin_uv = 0, vdd_ov = 0, vdd_uv = 0;
  logic          adc_done = 0, rd_en = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rd_data;
  logic          rd_valid, irq_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0]    m_mask = 8'h00, m_cfg = 8'h1F;
  logic [5:0]    m_s1 = '0;
  logic [4*NC-1:0] m_sc = '0;

  always #4 clk = ~clk;

  fault_status_regs #(.NUM_CH(NC), .ADDR_W(AW), .PART_ID(PID), .REV(RV)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin),
    .ch_ts(ch_ts), .ch_oc(ch_oc), .ch_ov(ch_ov), .ch_uv(ch_uv),
    .iset_flt(iset_flt), .vin_ov(vin_ov), .vin_uv(vin_uv),
    .vdd_ov(vdd_ov), .vdd_uv(vdd_uv), .adc_done(adc_done),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq_n(irq_n)
  );

  function automatic logic [7:0] exp_read(logic [AW-1:0] a);
    case (a)
      4'd0:    return m_mask;
      4'd1:    return m_cfg;
      4'd2:    return {2'b00, PID, RV};
      4'd3:    return {2'b00, m_s1};
      4'd4:    return m_sc[7:0];
      4'd5:    return m_sc[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_irq_n();
    logic ts = 0, oc = 0, ov = 0, uv = 0, h;
    for (int c = 0; c < NC; c++) begin
      ts |= m_sc[4*c+3]; oc |= m_sc[4*c+2];
      ov |= m_sc[4*c+1]; uv |= m_sc[4*c];
    end
    h = m_s1[5] | (m_s1[4] & ~m_mask[6])
      | ((m_s1[1] | m_s1[0]) & ~m_mask[4])
      | ((m_s1[3] | m_s1[2]) & ~m_mask[3])
      | (ts & ~m_mask[5]) | (oc & ~m_mask[2])
      | (ov & ~m_mask[1]) | (uv & ~m_mask[0]);
    return ~(en_pin & h);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive port, advance model, check after the edge
  task automatic step(bit rd, bit wr, logic [AW-1:0] a, logic [7:0] d, string tag);
    logic st, lv;
    logic [5:0] l1, c1;
    logic [4*NC-1:0] lc, cc;
    logic [7:0] e_rd;
    rd_en = rd; wr_en = wr; addr = a; wdata = d;
    st = m_mask[7] && (m_cfg[3:0] == 4'h0) && en_pin;
    lv = m_cfg[4];
    l1 = {iset_flt, adc_done, st | vin_ov, ~st & vin_uv, st | vdd_ov, ~st & vdd_uv};
    for (int c = 0; c < NC; c++)
      lc[4*c +: 4] = {ch_ts[c], ch_oc[c], st | ch_ov[c], ~st & ch_uv[c]};
    c1 = (rd && a == 4'd3) ? 6'h3F : 6'h00;
    if (rd && a == 4'd6) c1[4] = 1'b1;
    for (int c = 0; c < NC; c++)
      cc[4*c +: 4] = (rd && a == 4'(4 + c / 2)) ? 4'hF : 4'h0;
    e_rd = exp_read(a);
    for (int i = 0; i < 6; i++)
      if (c1[i] && !lv) m_s1[i] = 1'b0;
      else if (en_pin) m_s1[i] = lv ? l1[i] : (m_s1[i] | l1[i]);
    for (int i = 0; i < 4*NC; i++)
      if (cc[i] && !lv) m_sc[i] = 1'b0;
      else if (en_pin) m_sc[i] = lv ? lc[i] : (m_sc[i] | lc[i]);
    if (wr && a == 4'd0) m_mask = d;
    if (wr && a == 4'd1) m_cfg = d;
    @(posedge clk); #2;
    chk(en_pin ? "R8 irq_n" : "R7 irq_n", {7'b0, irq_n}, {7'b0, exp_irq_n()});
    chk("R2 rd_valid", {7'b0, rd_valid}, {7'b0, rd});
    if (rd) chk(tag, rd_data, e_rd);
    @(negedge clk);
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    step(1, 0, a, 8'h00, tag);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d, string tag);
    step(0, 1, a, d, tag);
  endtask

  task automatic idle();
    step(0, 0, '0, 8'h00, "R5 idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd0, "R1 mask");
    rd(4'd1, "R1 cfg");
    chk("R1 cfg literal", rd_data, 8'h1F);
    rd(4'd3, "R1 stat1");
    rd(4'd4, "R1 ch12");
    rd(4'd5, "R1 ch34");
    // R2 identity and unmapped
    rd(4'd2, "R2 id");
    chk("R2 id literal", rd_data, 8'h15);
    rd(4'd7, "R2 unmapped");
    // R3 writes
    wr(4'd0, 8'h55, "R3");
    rd(4'd0, "R3 mask");
    wr(4'd2, 8'hFF, "R3");
    wr(4'd3, 8'hFF, "R3");
    wr(4'd5, 8'hFF, "R3");
    rd(4'd2, "R3 id unchanged");
    rd(4'd3, "R3 stat1 unchanged");
    rd(4'd5, "R3 ch34 unchanged");
    wr(4'd0, 8'h00, "R3");
    // R5 latched mode with R4 layout
    en_pin = 1'b1;
    wr(4'd1, 8'h00, "R5");
    ch_oc[2] = 1'b1; idle();
    ch_oc[2] = 1'b0; idle();
    rd(4'd5, "R4 ch3 oc");
    chk("R4 ch3 oc literal", rd_data, 8'h04);
    rd(4'd5, "R5 cleared");
    ch_ov[1] = 1'b1; idle(); ch_ov[1] = 1'b0;
    rd(4'd4, "R4 ch2 ov");
    chk("R4 ch2 ov literal", rd_data, 8'h20);
    vin_uv = 1'b1; idle();
    rd(4'd3, "R5 persist first");
    rd(4'd3, "R5 persist second");
    rd(4'd3, "R5 persist third");
    vin_uv = 1'b0; idle();
    rd(4'd3, "R5 clear");
    // R6 live mode
    wr(4'd1, 8'h10, "R6");
    vdd_ov = 1'b1; idle();
    rd(4'd3, "R6 live set");
    rd(4'd3, "R6 read no clear");
    vdd_ov = 1'b0; idle();
    rd(4'd3, "R6 live drop");
    // R7 enable pin low
    wr(4'd1, 8'h00, "R7");
    ch_ts[0] = 1'b1; idle();
    en_pin = 1'b0; ch_ts[0] = 1'b0; ch_uv[1] = 1'b1;
    idle(); idle();
    rd(4'd4, "R7 held");
    chk("R7 held literal", rd_data, 8'h08);
    rd(4'd4, "R7 cleared while off");
    ch_uv[1] = 1'b0; en_pin = 1'b1;
    // R8 masking, R10 conversion clear
    wr(4'd0, 8'h7F, "R8");
    iset_flt = 1'b1; idle();
    chk("R8 iset unmaskable", {7'b0, irq_n}, 8'h00);
    iset_flt = 1'b0; rd(4'd3, "R8 clear");
    adc_done = 1'b1; idle(); adc_done = 1'b0;
    idle();
    chk("R8 acc masked", {7'b0, irq_n}, 8'h01);
    wr(4'd0, 8'h00, "R8");
    rd(4'd6, "R10 adc read");
    rd(4'd3, "R10 acc cleared");
    // R9 self-test
    rd(4'd4, "R9 pre"); rd(4'd5, "R9 pre");
    wr(4'd0, 8'h80, "R9");
    vin_uv = 1'b1; ch_uv = '1; idle(); idle();
    rd(4'd3, "R9 stat1");
    chk("R9 stat1 literal", rd_data, 8'h0A);
    rd(4'd4, "R9 ch12");
    chk("R9 ch12 literal", rd_data, 8'h22);
    vin_uv = 1'b0; ch_uv = '0;
    wr(4'd1, 8'h11, "R9");
    idle(); idle();
    rd(4'd3, "R9 no effect when enabled");
    rd(4'd4, "R9 no effect ch");
    wr(4'd0, 8'h00, "R9");
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int r;
      logic [AW-1:0] a;
      r = $urandom_range(0, 99);
      ch_ts = ($urandom_range(0, 7) == 0) ? NC'($urandom) : '0;
      ch_oc = ($urandom_range(0, 7) == 0) ? NC'($urandom) : '0;
      ch_ov = ($urandom_range(0, 7) == 0) ? NC'($urandom) : '0;
      ch_uv = ($urandom_range(0, 7) == 0) ? NC'($urandom) : '0;
      {iset_flt, vin_ov, vin_uv, vdd_ov, vdd_uv, adc_done} =
        ($urandom_range(0, 5) == 0) ? 6'($urandom) : 6'h00;
      if (r < 4) en_pin = ~en_pin;
      if (r < 10) begin
        a = AW'($urandom_range(0, 3));
        wr(a, 8'($urandom), "R3 random write");
      end else if (r < 60) begin
        a = AW'($urandom_range(0, 7));
        rd(a, m_cfg[4] ? "R6 random read" : "R5 random read");
      end else begin
        idle();
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule